// File: doc/BRIEF.md
# Converter Link Bring-Up Sequencer

This block is a control state machine that brings a high-speed converter's serial data link into service in a fixed order. A start pulse sets it off. It writes the converter's registers through a request/acknowledge port: it first disables the link, then writes the data format and calibration settings, then re-enables the link and starts a calibration. After calibration completes, it asks a reference-pulse generator for a SYSREF edge, which fixes the local multiframe clock phase. Only then does it enable the local receiver and hold SYNC~ low until the receiver reports code group synchronization.

After code group synchronization, SYNC~ is released so that the initial lane alignment sequence can run. The block reports link-up once the receiver signals that the alignment sequence has ended. The calibration wait, the code group wait and the alignment wait each have a cycle limit set on an input port. If calibration runs past its limit, the block stops with an error. If either of the two link waits runs past its limit, the block pulls SYNC~ low again and retries from the SYNC~ step. When the allowed retries are used up, it stops with an error code that names the step that failed.

Top module: `link_bringup_seq`

## Requirements
- R1: After synchronous reset, and while idle, sync_n=0, link_up=0, reg_req=0, rx_enable=0, sysref_req=0, busy=0 and err=0. A one-cycle start pulse in idle begins the sequence. A start pulse while busy has no effect and does not restart the register writes.
- R2: The sequence issues exactly six register writes, as (address, data) pairs, in this order:
  1. (0x20, 0x00): link disabled.
  2. (0x21, {2'b00, cfg_ddr, cfg_scram, cfg_decim[3:0]}).
  3. (0x22, {3'b000, cfg_kminus1[4:0]}).
  4. (0x23, cfg_cal).
  5. (0x20, 0x01): link enabled.
  6. (0x24, 0x01): calibration start.
- R3: reg_req stays high with reg_addr and reg_wdata stable until reg_ack is seen. The next write begins only after that acknowledge.
- R4: sysref_req rises only after cal_done is seen following the last write. If cal_done is still absent cal_timeout cycles after the calibration wait begins, the block stops in error with err_code=1. In that case sysref_req is never raised.
- R5: sysref_req is held high until sysref_edge is seen. rx_enable rises only after that edge and is never high while sysref_req is high.
- R6: Once rx_enable is high, sync_n stays low until cgs_lock is seen, then goes high.
- R7: While sync_n is high, link_up rises only after ila_done is seen. From then on link_up=1, done=1, busy=0 and err=0.
- R8: A timeout in the code group wait (sync_timeout) or in the alignment wait (ila_timeout) drives sync_n low again and restarts the SYNC~ step. The block allows up to MAX_RETRY retries, which is 2 by default, giving 3 attempts.
- R9: When retries are exhausted, the block stops in error with sync_n=0 and err_code=2 for a code group timeout or 3 for an alignment timeout. err is high exactly when err_code is non-zero.
- R10: The link-up and error states hold until reset. Reset from any state returns the block to the idle outputs of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, used only when idle |
| cfg_decim | input | 4 | Decimation setting |
| cfg_scram | input | 1 | Scrambler enable |
| cfg_kminus1 | input | 5 | Frames per multiframe minus one |
| cfg_ddr | input | 1 | Double data rate select |
| cfg_cal | input | 8 | Calibration settings byte |
| cal_timeout | input | 16 | Calibration wait limit in cycles |
| sync_timeout | input | 16 | Code group wait limit in cycles |
| ila_timeout | input | 16 | Alignment wait limit in cycles |
| reg_req | output | 1 | Register write request |
| reg_addr | output | 8 | Register write address |
| reg_wdata | output | 8 | Register write data |
| reg_ack | input | 1 | Register write acknowledge |
| cal_done | input | 1 | Calibration finished |
| sysref_req | output | 1 | Request for a SYSREF edge |
| sysref_edge | input | 1 | SYSREF edge has been issued |
| rx_enable | output | 1 | Local receiver enable |
| cgs_lock | input | 1 | Receiver code group synchronization |
| ila_done | input | 1 | End of lane alignment sequence |
| sync_n | output | 1 | SYNC~ to the converter, active low |
| link_up | output | 1 | Link in normal data mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| err | output | 1 | Sequence stopped on a failure |
| err_code | output | 2 | 0 none, 1 calibration, 2 code group, 3 alignment |

## Verification
A wrong state or step index shows up at the register port within one write. An address or data byte appears out of order, a write repeats, or a write goes out without an acknowledge. A wrong transition in the wait states shows as a SYSREF request before calibration completes, a receiver enable before the SYSREF edge, or an early release of SYNC~. Each of these is visible in the cycle after the bad transition. A miscounted retry or timer only shows once a wait limit runs out, so it is detected by counting SYNC~ rising edges and by when err rises relative to the programmed limits.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int DEC_W = 4;
    localparam int KM1_W = 5;
    localparam int N_WR  = 6;
    localparam int IDX_W = $clog2(N_WR);

    localparam logic [7:0] A_LINK = 8'h20;
    localparam logic [7:0] A_FMT  = 8'h21;
    localparam logic [7:0] A_KM1  = 8'h22;
    localparam logic [7:0] A_CAL  = 8'h23;
    localparam logic [7:0] A_CMD  = 8'h24;

    typedef enum logic [2:0] {
        S_IDLE, S_WR, S_CAL, S_SREF, S_CGS, S_ILA, S_UP, S_ERR
    } st_t;

    typedef enum logic [1:0] {
        E_NONE = 2'd0, E_CAL = 2'd1, E_CGS = 2'd2, E_ILA = 2'd3
    } err_t;

    typedef struct packed {
        logic [DEC_W-1:0] decim;
        logic             scram;
        logic [KM1_W-1:0] km1;
        logic             ddr;
        logic [7:0]       cal;
    } cfg_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } wr_t;

    function automatic wr_t wr_entry(input logic [IDX_W-1:0] i, input cfg_t c);
        wr_t r;
        case (i)
            3'd0:    r = '{addr: A_LINK, data: 8'h00};
            3'd1:    r = '{addr: A_FMT,  data: {2'b00, c.ddr, c.scram, c.decim}};
            3'd2:    r = '{addr: A_KM1,  data: {3'b000, c.km1}};
            3'd3:    r = '{addr: A_CAL,  data: c.cal};
            3'd4:    r = '{addr: A_LINK, data: 8'h01};
            default: r = '{addr: A_CMD,  data: 8'h01};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt <= '0;
        else if (cnt != '1)       cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt >= limit);
endmodule

// File: rtl/lbs_wr_table.sv
module lbs_wr_table
    import lbs_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  cfg_t             cfg,
    output logic [7:0]       addr,
    output logic [7:0]       data,
    output logic             last
);
    wr_t ent;
    always_comb begin
        ent  = wr_entry(idx, cfg);
        addr = ent.addr;
        data = ent.data;
        last = (idx == IDX_W'(N_WR - 1));
    end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import lbs_pkg::*;
#(
    parameter int TW        = 16,
    parameter int MAX_RETRY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    cfg_decim,
    input  logic          cfg_scram,
    input  logic [4:0]    cfg_kminus1,
    input  logic          cfg_ddr,
    input  logic [7:0]    cfg_cal,
    input  logic [TW-1:0] cal_timeout,
    input  logic [TW-1:0] sync_timeout,
    input  logic [TW-1:0] ila_timeout,
    output logic          reg_req,
    output logic [7:0]    reg_addr,
    output logic [7:0]    reg_wdata,
    input  logic          reg_ack,
    input  logic          cal_done,
    output logic          sysref_req,
    input  logic          sysref_edge,
    output logic          rx_enable,
    input  logic          cgs_lock,
    input  logic          ila_done,
    output logic          sync_n,
    output logic          link_up,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [1:0]    err_code
);
    localparam int RTW = $clog2(MAX_RETRY + 2);

    st_t              state_q, state_d;
    err_t             err_q, err_d;
    logic [RTW-1:0]   retry_q, retry_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             restart, tmo, wr_last, t_run;
    logic [TW-1:0]    t_limit;
    cfg_t             cfg;

    assign cfg = '{decim: cfg_decim, scram: cfg_scram, km1: cfg_kminus1,
                   ddr: cfg_ddr, cal: cfg_cal};

    lbs_wr_table u_tab (
        .idx  (idx_q),
        .cfg  (cfg),
        .addr (reg_addr),
        .data (reg_wdata),
        .last (wr_last)
    );

    always_comb begin
        t_run = 1'b1;
        case (state_q)
            S_CAL:   t_limit = cal_timeout;
            S_CGS:   t_limit = sync_timeout;
            S_ILA:   t_limit = ila_timeout;
            default: begin t_limit = '0; t_run = 1'b0; end
        endcase
    end

    lbs_wait_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (t_run),
        .clear   ((state_d != state_q) || restart),
        .limit   (t_limit),
        .expired (tmo)
    );

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        retry_d = retry_q;
        idx_d   = idx_q;
        restart = 1'b0;
        case (state_q)
            S_IDLE: if (start) begin
                state_d = S_WR;
                idx_d   = '0;
                retry_d = '0;
                err_d   = E_NONE;
            end
            S_WR: if (reg_ack) begin
                if (wr_last) state_d = S_CAL;
                else         idx_d   = idx_q + 1'b1;
            end
            S_CAL: begin
                if (cal_done) state_d = S_SREF;
                else if (tmo) begin state_d = S_ERR; err_d = E_CAL; end
            end
            S_SREF: if (sysref_edge) state_d = S_CGS;
            S_CGS, S_ILA: begin
                if (state_q == S_CGS && cgs_lock)      state_d = S_ILA;
                else if (state_q == S_ILA && ila_done) state_d = S_UP;
                else if (tmo) begin
                    if (retry_q < RTW'(MAX_RETRY)) begin
                        retry_d = retry_q + 1'b1;
                        state_d = S_CGS;
                        restart = 1'b1;
                    end else begin
                        state_d = S_ERR;
                        err_d   = (state_q == S_CGS) ? E_CGS : E_ILA;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            err_q   <= E_NONE;
            retry_q <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            retry_q <= retry_d;
            idx_q   <= idx_d;
        end
    end

    assign reg_req    = (state_q == S_WR);
    assign sysref_req = (state_q == S_SREF);
    assign rx_enable  = (state_q == S_CGS) || (state_q == S_ILA) || (state_q == S_UP);
    assign sync_n     = (state_q == S_ILA) || (state_q == S_UP);
    assign link_up    = (state_q == S_UP);
    assign done       = (state_q == S_UP);
    assign err        = (state_q == S_ERR);
    assign busy       = !(state_q inside {S_IDLE, S_UP, S_ERR});
    assign err_code   = err_q;

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_wdata));

    // R4
    sref_after_cal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sysref_req) |-> $past(cal_done));

    // R5
    rx_after_sref_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_enable) |-> $past(sysref_edge) && !sysref_req);

    // R6
    sync_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> $past(cgs_lock) && rx_enable);

    // R7
    up_after_ila_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> $past(ila_done) && sync_n);

    // R9
    err_code_chk: assert property (@(posedge clk) disable iff (rst)
        err == (err_code != 2'd0));

    // R10
    terminal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (link_up || err) |=> $stable(link_up) && $stable(err) && $stable(err_code));
endmodule

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;
    logic        clk = 1'b0;
    logic        rst, start;
    logic [3:0]  cfg_decim;
    logic        cfg_scram, cfg_ddr;
    logic [4:0]  cfg_kminus1;
    logic [7:0]  cfg_cal;
    logic [15:0] cal_timeout, sync_timeout, ila_timeout;
    logic        reg_req, reg_ack, cal_done, sysref_req, sysref_edge;
    logic [7:0]  reg_addr, reg_wdata;
    logic        rx_enable, cgs_lock, ila_done, sync_n, link_up, busy, done, err;
    logic [1:0]  err_code;

    int total = 0, bad = 0;
    int ack_delay = 0;
    logic log_clr = 1'b0;
    int n_wr, dly_cnt, sr_cnt, sync_rises;
    logic [7:0] log_a [16];
    logic [7:0] log_d [16];
    logic sync_prev;

    always #2.5 clk = ~clk;

    link_bringup_seq dut (.*);

    // register port responder
    always @(posedge clk) begin
        if (rst || log_clr) begin
            reg_ack <= 1'b0; n_wr <= 0; dly_cnt <= 0;
        end else if (reg_req && !reg_ack) begin
            if (dly_cnt >= ack_delay) begin
                reg_ack <= 1'b1; dly_cnt <= 0;
                if (n_wr < 16) begin log_a[n_wr] <= reg_addr; log_d[n_wr] <= reg_wdata; end
                n_wr <= n_wr + 1;
            end else dly_cnt <= dly_cnt + 1;
        end else reg_ack <= 1'b0;
    end

    // reference pulse generator responder
    always @(posedge clk) begin
        if (rst || log_clr) begin
            sysref_edge <= 1'b0; sr_cnt <= 0;
        end else if (sysref_req && !sysref_edge) begin
            sysref_edge <= 1'b1; sr_cnt <= sr_cnt + 1;
        end else sysref_edge <= 1'b0;
    end

    always @(posedge clk) begin
        sync_prev <= sync_n;
        if (rst || log_clr) sync_rises <= 0;
        else if (sync_n && !sync_prev) sync_rises <= sync_rises + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; cal_done = 1'b0; cgs_lock = 1'b0; ila_done = 1'b0;
        log_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; log_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk(sync_n == 0,    {tag, " R1 sync_n"}, sync_n, 0);
        chk(link_up == 0,   {tag, " R1 link_up"}, link_up, 0);
        chk(reg_req == 0,   {tag, " R1 reg_req"}, reg_req, 0);
        chk(rx_enable == 0, {tag, " R1 rx_enable"}, rx_enable, 0);
        chk(sysref_req == 0,{tag, " R1 sysref_req"}, sysref_req, 0);
        chk(busy == 0 && err == 0, {tag, " R1 busy/err"}, {busy, err}, 0);
    endtask

    task automatic check_writes();
        logic [7:0] ea [6];
        logic [7:0] ed [6];
        ea = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h20, 8'h24};
        ed = '{8'h00, {2'b00, cfg_ddr, cfg_scram, cfg_decim}, {3'b000, cfg_kminus1},
               cfg_cal, 8'h01, 8'h01};
        chk(n_wr == 6, "R2 write count", n_wr, 6);
        for (int i = 0; i < 6; i++) begin
            chk(log_a[i] == ea[i], "R2 write addr", log_a[i], ea[i]);
            chk(log_d[i] == ed[i], "R2 write data", log_d[i], ed[i]);
        end
    endtask

    task automatic wait_writes();
        for (int i = 0; i < 500 && n_wr < 6; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check_idle("reset");
    endtask

    task automatic t_full(input int dly, input bit poke);
        do_reset();
        ack_delay = dly;
        pulse_start();
        chk(busy == 1, "R1 busy after start", busy, 1);
        if (poke) begin
            for (int i = 0; i < 200 && n_wr < 2; i++) @(negedge clk);
            pulse_start();   // ignored while busy
        end
        wait_writes();
        repeat (4) @(negedge clk);
        chk(sysref_req == 0, "R4 no sysref before cal_done", sysref_req, 0);
        chk(reg_req == 0, "R3 no extra write", reg_req, 0);
        cal_done = 1'b1;
        for (int i = 0; i < 50 && !sysref_req && !rx_enable; i++) @(negedge clk);
        chk(sysref_req == 1 || sr_cnt == 1, "R4 sysref after cal", sysref_req, 1);
        chk(!(rx_enable && sysref_req), "R5 rx off during sysref", rx_enable, 0);
        for (int i = 0; i < 50 && !rx_enable; i++) @(negedge clk);
        chk(rx_enable == 1, "R5 rx enabled", rx_enable, 1);
        chk(sr_cnt == 1, "R5 one sysref edge", sr_cnt, 1);
        repeat (5) @(negedge clk);
        chk(sync_n == 0, "R6 sync low awaiting cgs", sync_n, 0);
        cgs_lock = 1'b1;
        for (int i = 0; i < 50 && !sync_n; i++) @(negedge clk);
        chk(sync_n == 1, "R6 sync released", sync_n, 1);
        repeat (3) @(negedge clk);
        chk(link_up == 0, "R7 no link before ila", link_up, 0);
        ila_done = 1'b1;
        for (int i = 0; i < 50 && !link_up; i++) @(negedge clk);
        chk(link_up == 1 && done == 1, "R7 link up", {link_up, done}, 3);
        chk(busy == 0 && err == 0, "R7 busy/err clear", {busy, err}, 0);
        cal_done = 0; cgs_lock = 0; ila_done = 0;
        repeat (10) @(negedge clk);
        chk(link_up == 1 && sync_n == 1, "R10 link held", {link_up, sync_n}, 3);
        check_writes();
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        check_idle("R10 reset from up");
    endtask

    task automatic t_cal_timeout();
        do_reset();
        ack_delay = 0;
        pulse_start();
        wait_writes();
        repeat (20) @(negedge clk);
        chk(err == 0 && busy == 1, "R4 still waiting cal", err, 0);
        repeat (40) @(negedge clk);
        chk(err == 1 && err_code == 2'd1, "R4 cal timeout code", err_code, 1);
        chk(sr_cnt == 0 && sync_n == 0, "R4 no sysref after fail", sr_cnt, 0);
        repeat (10) @(negedge clk);
        chk(err == 1 && err_code == 2'd1, "R10 err held", err_code, 1);
    endtask

    task automatic t_cgs_timeout();
        int lows = 0;
        do_reset();
        pulse_start();
        wait_writes();
        cal_done = 1'b1;
        for (int i = 0; i < 50 && !rx_enable; i++) @(negedge clk);
        repeat (50) @(negedge clk);
        chk(err == 0 && busy == 1, "R8 cgs retry in progress", err, 0);
        for (int i = 0; i < 150; i++) begin
            if (sync_n == 0) lows++;
            @(negedge clk);
        end
        chk(lows == 150, "R8 sync held low across retries", lows, 150);
        chk(err == 1 && err_code == 2'd2, "R9 cgs error code", err_code, 2);
        chk(sync_n == 0 && link_up == 0, "R9 sync low on error", sync_n, 0);
    endtask

    task automatic t_ila_fail();
        do_reset();
        pulse_start();
        wait_writes();
        cal_done = 1'b1; cgs_lock = 1'b1;
        for (int i = 0; i < 300 && !err; i++) @(negedge clk);
        chk(sync_rises == 3, "R8 three ila attempts", sync_rises, 3);
        chk(err == 1 && err_code == 2'd3, "R9 ila error code", err_code, 3);
        chk(sync_n == 0, "R9 sync low after ila fail", sync_n, 0);
    endtask

    task automatic t_ila_retry_ok();
        do_reset();
        pulse_start();
        wait_writes();
        cal_done = 1'b1; cgs_lock = 1'b1;
        for (int i = 0; i < 200 && sync_rises < 1; i++) @(negedge clk);
        for (int i = 0; i < 100 && sync_n; i++) @(negedge clk);
        chk(sync_n == 0 && err == 0, "R8 sync pulled low on ila timeout", sync_n, 0);
        for (int i = 0; i < 100 && sync_rises < 2; i++) @(negedge clk);
        ila_done = 1'b1;
        for (int i = 0; i < 50 && !link_up; i++) @(negedge clk);
        chk(link_up == 1 && sync_rises == 2, "R8 retry succeeds", sync_rises, 2);
    endtask

    initial begin
        cfg_decim = 4'd8; cfg_scram = 1'b1; cfg_kminus1 = 5'd23; cfg_ddr = 1'b0; cfg_cal = 8'h5A;
        cal_timeout = 16'd40; sync_timeout = 16'd30; ila_timeout = 16'd25;
        t_reset();
        t_full(0, 1'b0);
        cfg_decim = 4'd3; cfg_scram = 1'b0; cfg_kminus1 = 5'd31; cfg_ddr = 1'b1; cfg_cal = 8'hC3;
        t_full(3, 1'b1);
        t_cal_timeout();
        t_cgs_timeout();
        t_ila_fail();
        t_ila_retry_ok();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule